// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block steps a simple non-pipelined processor through the four phases of each instruction (fetch, decode, execute, write back) and owns its program counter. At the end of every instruction, in the write-back phase, it looks at two latched requests: a maskable one and a non-maskable one. When a request is accepted, the fetch of the following instruction is replaced by a fetch from that source's vector address. The address of the instruction that was blocked goes into a return register, and the maskable and non-maskable sources each have a return register of their own.

A return indication that arrives while the matching service routine is active puts the saved address back into the program counter, so the blocked instruction is fetched again from the start. The same return sends a one-cycle acknowledge to the device and clears that source's request latch. A global enable bit gates the maskable source. The non-maskable source does not look at it and has priority over the maskable one.

Top module: `irq_seq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to this state: `pc` = RESET_PC, `phase` = fetch, `irq_en` = 1, both service flags 0, both acknowledges 0, both return registers 0 and both request latches clear.
- R2: `phase` steps through fetch (0), decode (1), execute (2) and write back (3), then wraps to fetch, one step per clock. If no event is taken, `pc` moves forward by PC_STEP at each write-back edge.
- R3: A maskable request is accepted at a write-back edge when it is latched, `irq_en` = 1 and no service routine is active. On acceptance, `pc` becomes MVEC, `ret_m` takes the current `pc` + PC_STEP (the blocked instruction) and `svc_m` goes to 1.
- R4: Clearing the enable blocks maskable acceptance. A request raised while the enable is clear stays latched, and it is accepted at the first write-back edge after the enable is set again.
- R5: A latched non-maskable request is accepted at a write-back edge whenever `svc_n` = 0, whatever the value of `irq_en`. On acceptance, `pc` becomes NVEC, `ret_n` takes `pc` + PC_STEP and `svc_n` goes to 1.
- R6: When both requests are pending at the same write-back edge, the non-maskable one is accepted. The maskable one stays latched and is accepted at the next write-back edge after the non-maskable return.
- R7: While a maskable or non-maskable service routine is active, no maskable request is accepted.
- R8: If `rti_evt` is high at a write-back edge while `svc_m` = 1 and `svc_n` = 0, then `pc` is loaded from `ret_m`, `svc_m` clears, and `ack_m` is high for exactly the next cycle, which is a fetch cycle.
- R9: If `rtn_evt` is high at a write-back edge while `svc_n` = 1, then `pc` is loaded from `ret_n`, `svc_n` clears, and `ack_n` pulses for one cycle. A non-maskable entry taken inside a maskable routine returns into that routine.
- R10: A return indication with no matching active routine is ignored: `pc` moves forward by PC_STEP and no acknowledge is issued. This includes `rti_evt` while `svc_n` = 1.
- R11: `mask_off` sets `irq_en` to 0 and `mask_on` sets it to 1. When both are high in the same cycle, `mask_off` wins.
- R12: `pc` changes only at a write-back edge. It holds its value through fetch, decode and execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Maskable request (device data-ready) |
| nmi_req | input | 1 | Non-maskable request |
| mask_off | input | 1 | Clear the global maskable enable |
| mask_on | input | 1 | Set the global maskable enable |
| rti_evt | input | 1 | Maskable return indication, sampled at write back |
| rtn_evt | input | 1 | Non-maskable return indication, sampled at write back |
| pc | output | AW | Address of the current instruction |
| phase | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute, 3 write back |
| fetch_en | output | 1 | High during the fetch phase |
| irq_en | output | 1 | Global maskable enable |
| svc_m | output | 1 | Maskable service routine active |
| svc_n | output | 1 | Non-maskable service routine active |
| ack_m | output | 1 | One-cycle acknowledge to the maskable device |
| ack_n | output | 1 | One-cycle acknowledge to the non-maskable device |
| ret_m | output | AW | Maskable return register |
| ret_n | output | AW | Non-maskable return register |

## Verification
The stimulus is a sequence of whole instructions, each with a different mix of requests, enable changes and return indications. The cases are: a lone maskable entry and return, a request that waits behind a cleared enable, a non-maskable entry nested inside a maskable routine, both requests arriving together, and returns with no matching routine. Together these separate the priority rule, the hold-off during service and the choice of return register, and they show whether the blocked address or the one after it is restored. Every instruction also checks that the acknowledge has dropped and that `pc` has held by the decode phase. A reset in the middle of a service routine is applied last.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_DEC   = 2'd1,
        PH_EXE   = 2'd2,
        PH_WB    = 2'd3
    } phase_t;

    localparam int NSRC  = 2;
    localparam int SRC_M = 0;
    localparam int SRC_N = 1;

    typedef struct packed {
        logic ret_n;
        logic ret_m;
        logic take_n;
        logic take_m;
    } seq_ctl_t;

    function automatic phase_t phase_after(phase_t p);
        return phase_t'(p + 2'd1);
    endfunction

endpackage

// File: rtl/irq_phase_ctr.sv
module irq_phase_ctr
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   at_wb
);
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_after(phase);
    end

    assign at_wb = (phase == PH_WB);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (clr) pend <= req;
        else          pend <= pend | req;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic            at_wb,
    input  logic [NSRC-1:0] pend,
    input  logic            en,
    input  logic            svc_m,
    input  logic            svc_n,
    input  logic            rti,
    input  logic            rtn,
    output seq_ctl_t        ctl
);
    logic any_ret;

    always_comb begin
        ctl.ret_n  = at_wb & rtn & svc_n;
        ctl.ret_m  = at_wb & rti & svc_m & ~svc_n;
        any_ret    = ctl.ret_n | ctl.ret_m;
        ctl.take_n = at_wb & ~any_ret & pend[SRC_N] & ~svc_n;
        ctl.take_m = at_wb & ~any_ret & ~ctl.take_n & pend[SRC_M]
                     & en & ~svc_m & ~svc_n;
    end
endmodule

// File: rtl/irq_pc_unit.sv
module irq_pc_unit
    import irq_seq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int unsigned RESET_PC = 'h100,
    parameter int unsigned PC_STEP  = 4,
    parameter int unsigned MVEC     = 'h40,
    parameter int unsigned NVEC     = 'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          at_wb,
    input  seq_ctl_t      ctl,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ret_m,
    output logic [AW-1:0] ret_n,
    output logic          svc_m,
    output logic          svc_n,
    output logic          ack_m,
    output logic          ack_n
);
    localparam logic [AW-1:0] STEP_W  = AW'(PC_STEP);
    localparam logic [AW-1:0] START_W = AW'(RESET_PC);
    localparam logic [AW-1:0] MVEC_W  = AW'(MVEC);
    localparam logic [AW-1:0] NVEC_W  = AW'(NVEC);

    logic [AW-1:0] seq_pc;
    assign seq_pc = pc + STEP_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= START_W;
            ret_m <= '0;
            ret_n <= '0;
            svc_m <= 1'b0;
            svc_n <= 1'b0;
            ack_m <= 1'b0;
            ack_n <= 1'b0;
        end else begin
            ack_m <= ctl.ret_m;
            ack_n <= ctl.ret_n;
            if (ctl.ret_n) begin
                pc    <= ret_n;
                svc_n <= 1'b0;
            end else if (ctl.ret_m) begin
                pc    <= ret_m;
                svc_m <= 1'b0;
            end else if (ctl.take_n) begin
                ret_n <= seq_pc;
                pc    <= NVEC_W;
                svc_n <= 1'b1;
            end else if (ctl.take_m) begin
                ret_m <= seq_pc;
                pc    <= MVEC_W;
                svc_m <= 1'b1;
            end else if (at_wb) begin
                pc    <= seq_pc;
            end
        end
    end
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int unsigned RESET_PC = 'h100,
    parameter int unsigned PC_STEP  = 4,
    parameter int unsigned MVEC     = 'h40,
    parameter int unsigned NVEC     = 'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic          nmi_req,
    input  logic          mask_off,
    input  logic          mask_on,
    input  logic          rti_evt,
    input  logic          rtn_evt,
    output logic [AW-1:0] pc,
    output logic [1:0]    phase,
    output logic          fetch_en,
    output logic          irq_en,
    output logic          svc_m,
    output logic          svc_n,
    output logic          ack_m,
    output logic          ack_n,
    output logic [AW-1:0] ret_m,
    output logic [AW-1:0] ret_n
);
    phase_t          ph;
    logic            at_wb;
    logic [NSRC-1:0] req_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] pend_v;
    seq_ctl_t        ctl;

    irq_phase_ctr u_ph (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (ph),
        .at_wb (at_wb)
    );

    assign req_v[SRC_M] = irq_req;
    assign req_v[SRC_N] = nmi_req;
    assign clr_v[SRC_M] = ctl.ret_m;
    assign clr_v[SRC_N] = ctl.ret_n;

    for (genvar s = 0; s < NSRC; s++) begin : g_lat
        irq_req_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_v[s]),
            .clr   (clr_v[s]),
            .pend  (pend_v[s])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        irq_en <= 1'b1;
        else if (mask_off) irq_en <= 1'b0;
        else if (mask_on)  irq_en <= 1'b1;
    end

    irq_arbiter u_arb (
        .at_wb (at_wb),
        .pend  (pend_v),
        .en    (irq_en),
        .svc_m (svc_m),
        .svc_n (svc_n),
        .rti   (rti_evt),
        .rtn   (rtn_evt),
        .ctl   (ctl)
    );

    irq_pc_unit #(
        .AW       (AW),
        .RESET_PC (RESET_PC),
        .PC_STEP  (PC_STEP),
        .MVEC     (MVEC),
        .NVEC     (NVEC)
    ) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .at_wb (at_wb),
        .ctl   (ctl),
        .pc    (pc),
        .ret_m (ret_m),
        .ret_n (ret_n),
        .svc_m (svc_m),
        .svc_n (svc_n),
        .ack_m (ack_m),
        .ack_n (ack_n)
    );

    assign phase    = ph;
    assign fetch_en = (ph == PH_FETCH);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int          AW   = 16,
    parameter int unsigned MVEC = 'h40,
    parameter int unsigned NVEC = 'h80
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pc,
    input logic [1:0]    phase,
    input logic          irq_en,
    input logic          svc_m,
    input logic          svc_n,
    input logic          ack_m,
    input logic          ack_n
);
    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == 2'($past(phase) + 2'd1));

    // R12
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd3) |=> $stable(pc));

    // R3
    m_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_m) |-> pc == AW'(MVEC));

    // R4
    m_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_m) |-> $past(irq_en));

    // R5
    n_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_n) |-> pc == AW'(NVEC));

    // R8
    ack_m_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_m |-> (phase == 2'd0) && $fell(svc_m));

    // R9
    ack_n_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |=> !ack_n);
endmodule

bind irq_seq_top irq_seq_chk #(
    .AW   (AW),
    .MVEC (MVEC),
    .NVEC (NVEC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (pc),
    .phase  (phase),
    .irq_en (irq_en),
    .svc_m  (svc_m),
    .svc_n  (svc_n),
    .ack_m  (ack_m),
    .ack_n  (ack_n)
);

// File: tb/tb_irq_seq_top.sv
module tb_irq_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int NV = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 0, nmi_req = 0, mask_off = 0, mask_on = 0, rti_evt = 0, rtn_evt = 0;
    logic [AW-1:0] pc, ret_m, ret_n;
    logic [1:0] phase;
    logic fetch_en, irq_en, svc_m, svc_n, ack_m, ack_n;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq_top dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .mask_off(mask_off), .mask_on(mask_on), .rti_evt(rti_evt), .rtn_evt(rtn_evt),
        .pc(pc), .phase(phase), .fetch_en(fetch_en), .irq_en(irq_en),
        .svc_m(svc_m), .svc_n(svc_n), .ack_m(ack_m), .ack_n(ack_n),
        .ret_m(ret_m), .ret_n(ret_n)
    );

    // inputs {irq,nmi,off,on,rti,rtn}, pc, {svc_m,svc_n,ack_m,ack_n,en}, ret_m, ret_n
    localparam logic [58:0] VEC [NV] = '{
        {6'b000000, 16'h0104, 5'b00001, 16'h0000, 16'h0000}, // 0  R2
        {6'b100000, 16'h0040, 5'b10001, 16'h0108, 16'h0000}, // 1  R3
        {6'b000000, 16'h0044, 5'b10001, 16'h0108, 16'h0000}, // 2  R7
        {6'b000010, 16'h0108, 5'b00101, 16'h0108, 16'h0000}, // 3  R8
        {6'b001000, 16'h010C, 5'b00000, 16'h0108, 16'h0000}, // 4  R4
        {6'b100000, 16'h0110, 5'b00000, 16'h0108, 16'h0000}, // 5  R4
        {6'b000000, 16'h0114, 5'b00000, 16'h0108, 16'h0000}, // 6  R4
        {6'b000100, 16'h0040, 5'b10001, 16'h0118, 16'h0000}, // 7  R4
        {6'b010000, 16'h0080, 5'b11001, 16'h0118, 16'h0044}, // 8  R9
        {6'b000010, 16'h0084, 5'b11001, 16'h0118, 16'h0044}, // 9  R10
        {6'b000001, 16'h0044, 5'b10011, 16'h0118, 16'h0044}, // 10 R9
        {6'b000010, 16'h0118, 5'b00101, 16'h0118, 16'h0044}, // 11 R8
        {6'b110000, 16'h0080, 5'b01001, 16'h0118, 16'h011C}, // 12 R6
        {6'b000000, 16'h0084, 5'b01001, 16'h0118, 16'h011C}, // 13 R7
        {6'b000001, 16'h011C, 5'b00011, 16'h0118, 16'h011C}, // 14 R6
        {6'b000000, 16'h0040, 5'b10001, 16'h0120, 16'h011C}, // 15 R6
        {6'b000010, 16'h0120, 5'b00101, 16'h0120, 16'h011C}, // 16 R8
        {6'b000010, 16'h0124, 5'b00001, 16'h0120, 16'h011C}, // 17 R10
        {6'b011000, 16'h0080, 5'b01000, 16'h0120, 16'h0128}, // 18 R5
        {6'b000001, 16'h0128, 5'b00010, 16'h0120, 16'h0128}, // 19 R9
        {6'b101100, 16'h012C, 5'b00000, 16'h0120, 16'h0128}, // 20 R11
        {6'b000100, 16'h0040, 5'b10001, 16'h0130, 16'h0128}, // 21 R11
        {6'b000010, 16'h0130, 5'b00101, 16'h0130, 16'h0128}  // 22 R8
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R2";   1: return "R3";   2: return "R7";   3: return "R8";
            4, 5, 6, 7: return "R4";
            8, 10, 19: return "R9";
            9, 17: return "R10";
            11, 16, 22: return "R8";
            12, 14, 15: return "R6";
            13: return "R7";
            18: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        {irq_req, nmi_req, mask_off, mask_on, rti_evt, rtn_evt} = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] pc_f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(pc == 16'h0100, "R1", "pc", 32'(pc), 32'h100);
        chk(phase == 2'd0 && fetch_en, "R1", "phase", 32'(phase), 0);
        chk({svc_m, svc_n, ack_m, ack_n, irq_en} == 5'b00001, "R1", "flags",
            32'({svc_m, svc_n, ack_m, ack_n, irq_en}), 1);
        chk(ret_m == 0 && ret_n == 0, "R1", "ret regs", 32'({ret_m, ret_n}), 0);

        for (int i = 0; i < NV; i++) begin
            pc_f = pc;
            drive(VEC[i][58:53]);
            @(negedge clk);
            // R12 pc held into decode, R8 acknowledge lasts one cycle
            chk(phase == 2'd1 && pc == pc_f && !ack_m && !ack_n, "R12",
                "decode pc/ack", 32'({phase, ack_m, ack_n, pc}), 32'({2'd1, 2'b00, pc_f}));
            repeat (3) @(negedge clk);
            chk(phase == 2'd0 && pc == VEC[i][52:37], tag_of(i), "pc",
                32'(pc), 32'(VEC[i][52:37]));
            chk({svc_m, svc_n, ack_m, ack_n, irq_en} == VEC[i][36:32], tag_of(i), "flags",
                32'({svc_m, svc_n, ack_m, ack_n, irq_en}), 32'(VEC[i][36:32]));
            chk(ret_m == VEC[i][31:16] && ret_n == VEC[i][15:0], tag_of(i), "ret regs",
                32'({ret_m, ret_n}), 32'(VEC[i][31:0]));
        end

        // R1 reset during a non-maskable routine
        drive(6'b011000);
        repeat (4) @(negedge clk);
        drive(6'b000000);
        chk(svc_n && pc == 16'h0080, "R5", "nmi entry", 32'({svc_n, pc}), 32'h10080);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(pc == 16'h0100 && phase == 2'd0 && !svc_n && !svc_m && irq_en,
            "R1", "mid-service reset", 32'({irq_en, svc_m, svc_n, pc}), 32'h40100);
        repeat (4) @(negedge clk);
        // R1 latches cleared: no entry after reset
        chk(pc == 16'h0104 && !svc_n && !svc_m, "R1", "latch cleared",
            32'({svc_m, svc_n, pc}), 32'h0104);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule